// File: doc/BRIEF.md
# Peripheral autopoll and request framer

This block sits between a host command channel and a serial peripheral bus. It accepts whole host requests in one cycle, recognises a special request form that loads a 16-bit device poll mask, and forwards ordinary requests to the bus after it has checked their declared payload length. A non-zero poll mask starts a free-running 30 ms poll timer. On each expiry the block queries the bus with the mask. It skips the query while the host still holds unacknowledged peripheral data.

Each bus answer, or the failure of a length check, is written into a reply buffer held by the block. The block then pulses interrupt-set outputs. Explicit replies carry a small success or failure header. Poll results are stored raw. The interrupt storage and the host transport belong to the surrounding logic. The peripheral bus is a request/acknowledge port that returns a response length and data when it acknowledges. A build parameter removes the bus. The block then answers every ordinary request with the failure reply and never drives the port.

Top module: `periph_autopoll_framer`

## Requirements
- R1: A request of kind 0 whose byte 0 is 0x00 and byte 1 is 0x86 is a poll-mask setting. It takes effect only when the request length is exactly 4, and the mask is byte 2 as the high byte and byte 3 as the low byte. With any other length it is ignored: no interrupt, and the mask and timer schedule are unchanged.
- R2: Loading a mask equal to the current one has no effect on the timer schedule. A new non-zero mask restarts the timer, so the first poll query starts POLL_MS*CLK_KHZ cycles after the accepting edge. A zero mask stops polling.
- R3: On a timer expiry the bus is queried, with bus_poll_o high and the mask on bus_mask_o, only when irq_data_pending_i is low. A non-empty poll result is stored raw (size n, bytes in bus order), and irq_data_set_o and irq_auto_set_o pulse together. An empty result changes nothing.
- R4: The timer reloads at every expiry, whether the query ran, was skipped or returned nothing. Poll queries therefore start exactly one period apart.
- R5: A kind-0 request shorter than 2 bytes is ignored. For an ordinary request, byte 2 is the declared payload length. It must not exceed the request length minus 3 or PAYLOAD_CAP. A request that breaks either limit gets the failure reply and does not reach the bus.
- R6: An explicit reply of n>0 bytes is stored as 0x01, n, then the n data bytes (size n+2). An empty bus reply or a failed check stores the single byte 0x00 (size 1).
- R7: Every accepted ordinary request pulses irq_data_set_o once, without irq_auto_set_o.
- R8: A request of kind 1 with length 0 stops the timer and clears the mask. With any other length it is ignored.
- R9: Requests arriving while a bus transaction is outstanding are ignored.
- R10: With HAS_BUS=0 every ordinary request gets the failure reply and pulses irq_data_set_o. Mask settings and poll-off have no effect, and bus_req_o never rises.
- R11: An explicit bus request carries byte 0 on bus_cmd_o, the request length minus 3 on bus_len_o and bytes 3 onward on bus_data_o. All bus request outputs hold steady until bus_ack_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request strobe, one cycle |
| req_kind_i | input | 1 | 0 = bus request or mask setting, 1 = poll-off |
| req_len_i | input | REQ_LEN_W | Request length in bytes |
| req_data_i | input | MAX_REQ*8 | Request bytes, byte k at bits 8k+7:8k |
| irq_data_pending_i | input | 1 | Peripheral-data interrupt bit from host-side storage |
| bus_req_o | output | 1 | Bus transaction outstanding |
| bus_poll_o | output | 1 | Outstanding transaction is a poll query |
| bus_mask_o | output | 16 | Current device poll mask |
| bus_cmd_o | output | 8 | Command byte of an explicit request |
| bus_len_o | output | REQ_LEN_W | Payload byte count of an explicit request |
| bus_data_o | output | (MAX_REQ-3)*8 | Payload bytes of an explicit request |
| bus_ack_i | input | 1 | Bus completes the transaction |
| bus_rsp_len_i | input | 8 | Response byte count, valid with bus_ack_i |
| bus_rsp_data_i | input | MAX_RSP*8 | Response bytes, valid with bus_ack_i |
| reply_size_o | output | 8 | Reply buffer size in bytes |
| reply_data_o | output | (MAX_RSP+2)*8 | Reply buffer contents, byte 0 lowest |
| irq_data_set_o | output | 1 | Pulse: set the peripheral-data interrupt bit |
| irq_auto_set_o | output | 1 | Pulse: set the autopoll interrupt bit |

## Verification
The bench builds the block with MAX_REQ=8, MAX_RSP=4, PAYLOAD_CAP=3 and CLK_KHZ=1, which makes the 30 ms period 30 cycles. With a cap of 3 the payload cap is reachable, so the bench sweeps every request length from 2 to 8 against declared payload lengths 0 to 5, and against bus reply lengths 0 to 4. The short period lets the bench measure exact poll spacing across re-arming, same-mask reloads, suppression and poll-off within a few thousand cycles. A second instance with HAS_BUS=0 sees the same request stream.

// File: rtl/pafr_pkg.sv
`timescale 1ns/1ps
package pafr_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_EXPL, ST_POLL} pafr_state_t;
  typedef enum logic [1:0] {RK_FAIL, RK_EXPL, RK_POLL} reply_kind_t;
  localparam logic [7:0] MASK_TAG0 = 8'h00;
  localparam logic [7:0] MASK_TAG1 = 8'h86;
  localparam logic       KIND_BUS  = 1'b0;
  localparam logic       KIND_OFF  = 1'b1;
endpackage

// File: rtl/pafr_req_decode.sv
`timescale 1ns/1ps
module pafr_req_decode #(
  parameter int unsigned MAX_REQ     = 16,
  parameter int unsigned PAYLOAD_CAP = 252,
  localparam int REQ_LEN_W = $clog2(MAX_REQ + 1)
) (
  input  logic [REQ_LEN_W-1:0]     len_i,
  input  logic [MAX_REQ*8-1:0]     data_i,
  output logic                     short_o,
  output logic                     mask_form_o,
  output logic                     mask_ok_o,
  output logic [15:0]              mask_o,
  output logic                     len_ok_o,
  output logic [7:0]               cmd_o,
  output logic [REQ_LEN_W-1:0]     pl_len_o,
  output logic [(MAX_REQ-3)*8-1:0] payload_o
);
  import pafr_pkg::*;

  logic [7:0]  b0, b1, b2, b3;
  logic [31:0] len32, avail32, decl32;

  assign b0 = data_i[7:0];
  assign b1 = data_i[15:8];
  assign b2 = data_i[23:16];
  assign b3 = data_i[31:24];

  assign len32   = 32'(len_i);
  assign avail32 = len32 - 32'd3;
  assign decl32  = {24'd0, b2};

  assign short_o     = len32 < 32'd2;
  assign mask_form_o = !short_o && (b0 == MASK_TAG0) && (b1 == MASK_TAG1);
  assign mask_ok_o   = mask_form_o && (len32 == 32'd4);
  assign mask_o      = {b2, b3};

  // declared payload must fit the bytes present and the cap
  assign len_ok_o = (len32 >= 32'd3) && (decl32 <= avail32) &&
                    (decl32 <= 32'(PAYLOAD_CAP));

  assign cmd_o     = b0;
  assign pl_len_o  = (len32 >= 32'd3) ? REQ_LEN_W'(avail32) : '0;
  assign payload_o = data_i[MAX_REQ*8-1:24];
endmodule

// File: rtl/pafr_poll_timer.sv
`timescale 1ns/1ps
module pafr_poll_timer #(
  parameter int unsigned PERIOD = 30,
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic stop_i,
  output logic expire_o
);
  localparam logic [CW-1:0] RELOAD = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  assign expire_o = run_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (arm_i) begin
      cnt_q <= RELOAD;
      run_q <= 1'b1;
    end else if (stop_i) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= expire_o ? RELOAD : cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/pafr_reply_pack.sv
`timescale 1ns/1ps
module pafr_reply_pack #(
  parameter int unsigned MAX_RSP = 8,
  localparam int OUT_B = MAX_RSP + 2
) (
  input  pafr_pkg::reply_kind_t kind_i,
  input  logic [7:0]            rsp_len_i,
  input  logic [MAX_RSP*8-1:0]  rsp_data_i,
  output logic [7:0]            size_o,
  output logic [OUT_B*8-1:0]    data_o,
  output logic                  nonempty_o
);
  import pafr_pkg::*;

  logic [7:0] n;
  assign n          = (rsp_len_i > 8'(MAX_RSP)) ? 8'(MAX_RSP) : rsp_len_i;
  assign nonempty_o = n != 8'd0;

  always_comb begin
    unique case (kind_i)
      RK_POLL: size_o = n;
      RK_EXPL: size_o = nonempty_o ? n + 8'd2 : 8'd1;
      default: size_o = 8'd1;
    endcase
  end

  for (genvar k = 0; k < OUT_B; k++) begin : g_byte
    logic [7:0] poll_b, expl_b;
    if (k < MAX_RSP) begin : g_p
      assign poll_b = (8'(k) < n) ? rsp_data_i[k*8 +: 8] : 8'h00;
    end else begin : g_pz
      assign poll_b = 8'h00;
    end
    if (k == 0) begin : g_h0
      assign expl_b = 8'h01;
    end else if (k == 1) begin : g_h1
      assign expl_b = n;
    end else begin : g_d
      assign expl_b = (8'(k - 2) < n) ? rsp_data_i[(k-2)*8 +: 8] : 8'h00;
    end
    assign data_o[k*8 +: 8] = (kind_i == RK_POLL) ? poll_b :
                              ((kind_i == RK_EXPL) && nonempty_o) ? expl_b : 8'h00;
  end
endmodule

// File: rtl/periph_autopoll_framer.sv
`timescale 1ns/1ps
module periph_autopoll_framer #(
  parameter int unsigned MAX_REQ     = 16,
  parameter int unsigned MAX_RSP     = 8,
  parameter int unsigned PAYLOAD_CAP = 252,
  parameter int unsigned CLK_KHZ     = 125000,
  parameter int unsigned POLL_MS     = 30,
  parameter bit          HAS_BUS     = 1'b1,
  localparam int REQ_LEN_W   = $clog2(MAX_REQ + 1),
  localparam int POLL_CYCLES = CLK_KHZ * POLL_MS
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_valid_i,
  input  logic                         req_kind_i,
  input  logic [REQ_LEN_W-1:0]         req_len_i,
  input  logic [MAX_REQ*8-1:0]         req_data_i,
  input  logic                         irq_data_pending_i,
  output logic                         bus_req_o,
  output logic                         bus_poll_o,
  output logic [15:0]                  bus_mask_o,
  output logic [7:0]                   bus_cmd_o,
  output logic [REQ_LEN_W-1:0]         bus_len_o,
  output logic [(MAX_REQ-3)*8-1:0]     bus_data_o,
  input  logic                         bus_ack_i,
  input  logic [7:0]                   bus_rsp_len_i,
  input  logic [MAX_RSP*8-1:0]         bus_rsp_data_i,
  output logic [7:0]                   reply_size_o,
  output logic [(MAX_RSP+2)*8-1:0]     reply_data_o,
  output logic                         irq_data_set_o,
  output logic                         irq_auto_set_o
);
  import pafr_pkg::*;

  pafr_state_t st_q;
  logic [15:0] mask_q;

  logic                     d_short, d_mform, d_mok, d_len_ok;
  logic [15:0]              d_mask;
  logic [7:0]               d_cmd;
  logic [REQ_LEN_W-1:0]     d_pl_len;
  logic [(MAX_REQ-3)*8-1:0] d_payload;

  pafr_req_decode #(.MAX_REQ(MAX_REQ), .PAYLOAD_CAP(PAYLOAD_CAP)) u_dec (
    .len_i      (req_len_i),
    .data_i     (req_data_i),
    .short_o    (d_short),
    .mask_form_o(d_mform),
    .mask_ok_o  (d_mok),
    .mask_o     (d_mask),
    .len_ok_o   (d_len_ok),
    .cmd_o      (d_cmd),
    .pl_len_o   (d_pl_len),
    .payload_o  (d_payload)
  );

  logic take, off_go, mask_go, norm_go, expl_go, fail_go, poll_go;
  logic tmr_arm, tmr_stop, tmr_expire;
  logic has_bus;

  assign has_bus = HAS_BUS;
  assign take    = (st_q == ST_IDLE) && req_valid_i;
  assign off_go  = take && (req_kind_i == KIND_OFF) && (req_len_i == '0) && has_bus;
  assign mask_go = take && (req_kind_i == KIND_BUS) && d_mok && has_bus &&
                   (d_mask != mask_q);
  assign norm_go = take && (req_kind_i == KIND_BUS) && !d_short && !d_mform;
  assign expl_go = norm_go && has_bus && d_len_ok;
  assign fail_go = norm_go && !(has_bus && d_len_ok);
  // an incoming request or pending data skips this period's query
  assign poll_go = (st_q == ST_IDLE) && !req_valid_i && tmr_expire &&
                   !irq_data_pending_i && has_bus;

  assign tmr_arm  = mask_go && (d_mask != 16'd0);
  assign tmr_stop = off_go || (mask_go && (d_mask == 16'd0));

  pafr_poll_timer #(.PERIOD(POLL_CYCLES)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (tmr_arm),
    .stop_i  (tmr_stop),
    .expire_o(tmr_expire)
  );

  reply_kind_t                 pk_kind;
  logic [7:0]                  pk_size;
  logic [(MAX_RSP+2)*8-1:0]    pk_data;
  logic                        pk_nonempty;

  assign pk_kind = (st_q == ST_POLL) ? RK_POLL :
                   (st_q == ST_EXPL) ? RK_EXPL : RK_FAIL;

  pafr_reply_pack #(.MAX_RSP(MAX_RSP)) u_pack (
    .kind_i    (pk_kind),
    .rsp_len_i (bus_rsp_len_i),
    .rsp_data_i(bus_rsp_data_i),
    .size_o    (pk_size),
    .data_o    (pk_data),
    .nonempty_o(pk_nonempty)
  );

  logic done;
  assign done = bus_ack_i && (st_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q           <= ST_IDLE;
      mask_q         <= 16'd0;
      bus_req_o      <= 1'b0;
      bus_poll_o     <= 1'b0;
      bus_cmd_o      <= 8'd0;
      bus_len_o      <= '0;
      bus_data_o     <= '0;
      reply_size_o   <= 8'd0;
      reply_data_o   <= '0;
      irq_data_set_o <= 1'b0;
      irq_auto_set_o <= 1'b0;
    end else begin
      irq_data_set_o <= 1'b0;
      irq_auto_set_o <= 1'b0;
      if (fail_go) begin
        reply_size_o   <= pk_size;
        reply_data_o   <= pk_data;
        irq_data_set_o <= 1'b1;
      end
      if (mask_go) mask_q <= d_mask;
      if (off_go)  mask_q <= 16'd0;
      if (expl_go) begin
        st_q       <= ST_EXPL;
        bus_req_o  <= 1'b1;
        bus_poll_o <= 1'b0;
        bus_cmd_o  <= d_cmd;
        bus_len_o  <= d_pl_len;
        bus_data_o <= d_payload;
      end
      if (poll_go) begin
        st_q       <= ST_POLL;
        bus_req_o  <= 1'b1;
        bus_poll_o <= 1'b1;
      end
      if (done) begin
        st_q      <= ST_IDLE;
        bus_req_o <= 1'b0;
        if (st_q == ST_EXPL) begin
          reply_size_o   <= pk_size;
          reply_data_o   <= pk_data;
          irq_data_set_o <= 1'b1;
        end else if (pk_nonempty) begin
          reply_size_o   <= pk_size;
          reply_data_o   <= pk_data;
          irq_data_set_o <= 1'b1;
          irq_auto_set_o <= 1'b1;
        end
      end
    end
  end

  assign bus_mask_o = mask_q;
endmodule

// File: rtl/periph_autopoll_framer_chk.sv
`timescale 1ns/1ps
module periph_autopoll_framer_chk #(
  parameter int unsigned MAX_RSP = 8,
  parameter bit          HAS_BUS = 1'b1
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     irq_data_pending_i,
  input logic                     bus_req_o,
  input logic                     bus_poll_o,
  input logic [15:0]              bus_mask_o,
  input logic [7:0]               bus_cmd_o,
  input logic                     bus_ack_i,
  input logic [7:0]               reply_size_o,
  input logic [(MAX_RSP+2)*8-1:0] reply_data_o,
  input logic                     irq_data_set_o,
  input logic                     irq_auto_set_o
);
  a_r11_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_poll_o) &&
                                $stable(bus_cmd_o) && $stable(bus_mask_o));

  a_r3_auto_with_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_auto_set_o |-> irq_data_set_o);

  a_r3_poll_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_o) && bus_poll_o |-> !$past(irq_data_pending_i));

  a_r2_poll_mask_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_poll_o |-> bus_mask_o != 16'd0);

  a_r7_reply_present: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_data_set_o |-> reply_size_o != 8'd0);

  a_r6_ok_header: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_data_set_o && !irq_auto_set_o && reply_size_o != 8'd1 |->
      reply_data_o[7:0] == 8'h01 && reply_data_o[15:8] == reply_size_o - 8'd2);

  a_r6_fail_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_data_set_o && !irq_auto_set_o && reply_size_o == 8'd1 |->
      reply_data_o[7:0] == 8'h00);

  if (!HAS_BUS) begin : g_nobus
    a_r10_bus_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bus_req_o && !irq_auto_set_o);
  end
endmodule

bind periph_autopoll_framer periph_autopoll_framer_chk #(
  .MAX_RSP(MAX_RSP), .HAS_BUS(HAS_BUS)
) chk_i (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .irq_data_pending_i(irq_data_pending_i),
  .bus_req_o         (bus_req_o),
  .bus_poll_o        (bus_poll_o),
  .bus_mask_o        (bus_mask_o),
  .bus_cmd_o         (bus_cmd_o),
  .bus_ack_i         (bus_ack_i),
  .reply_size_o      (reply_size_o),
  .reply_data_o      (reply_data_o),
  .irq_data_set_o    (irq_data_set_o),
  .irq_auto_set_o    (irq_auto_set_o)
);

// File: tb/periph_autopoll_framer_tb_top.sv
`timescale 1ns/1ps
module periph_autopoll_framer_tb_top;
  localparam int MAX_REQ = 8;
  localparam int MAX_RSP = 4;
  localparam int CAP     = 3;
  localparam int PER     = 30;
  localparam int LW      = $clog2(MAX_REQ + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic                     req_valid = 1'b0;
  logic                     req_kind = 1'b0;
  logic [LW-1:0]            req_len = '0;
  logic [MAX_REQ*8-1:0]     req_data = '0;
  logic                     irq_pend;
  logic                     bus_req, bus_poll;
  logic [15:0]              bus_mask;
  logic [7:0]               bus_cmd;
  logic [LW-1:0]            bus_len;
  logic [(MAX_REQ-3)*8-1:0] bus_data;
  logic                     bus_ack = 1'b0;
  logic [7:0]               rsp_len_w = 8'd0;
  logic [MAX_RSP*8-1:0]     rsp_data_w = '0;
  logic [7:0]               rep_size;
  logic [(MAX_RSP+2)*8-1:0] rep_data;
  logic                     irq_d, irq_a;

  logic                     nb_req, nb_poll;
  logic [15:0]              nb_mask;
  logic [7:0]               nb_cmd;
  logic [LW-1:0]            nb_len;
  logic [(MAX_REQ-3)*8-1:0] nb_data;
  logic [7:0]               nb_size;
  logic [(MAX_RSP+2)*8-1:0] nb_rdata;
  logic                     nb_irq_d, nb_irq_a;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int set_cnt = 0, auto_cnt = 0, ack_cnt = 0;
  int poll_cnt = 0, last_poll_t = 0, bus_cnt = 0;
  int nb_set = 0, nb_auto = 0, nb_bus_seen = 0, norm_sent = 0;
  int bus_delay = 2, rsp_n = 0;
  logic [7:0]  rsp_seed = 8'h00;
  logic [7:0]  cap_cmd = 8'h00, cap_pl0 = 8'h00;
  logic [15:0] cap_mask = 16'h0;
  int          cap_len = 0;

  assign irq_pend = (set_cnt != ack_cnt);

  periph_autopoll_framer #(.MAX_REQ(MAX_REQ), .MAX_RSP(MAX_RSP), .PAYLOAD_CAP(CAP),
    .CLK_KHZ(1), .POLL_MS(PER), .HAS_BUS(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_kind_i(req_kind),
    .req_len_i(req_len), .req_data_i(req_data), .irq_data_pending_i(irq_pend),
    .bus_req_o(bus_req), .bus_poll_o(bus_poll), .bus_mask_o(bus_mask),
    .bus_cmd_o(bus_cmd), .bus_len_o(bus_len), .bus_data_o(bus_data),
    .bus_ack_i(bus_ack), .bus_rsp_len_i(rsp_len_w), .bus_rsp_data_i(rsp_data_w),
    .reply_size_o(rep_size), .reply_data_o(rep_data),
    .irq_data_set_o(irq_d), .irq_auto_set_o(irq_a));

  periph_autopoll_framer #(.MAX_REQ(MAX_REQ), .MAX_RSP(MAX_RSP), .PAYLOAD_CAP(CAP),
    .CLK_KHZ(1), .POLL_MS(PER), .HAS_BUS(1'b0)) dut_nobus_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_kind_i(req_kind),
    .req_len_i(req_len), .req_data_i(req_data), .irq_data_pending_i(1'b0),
    .bus_req_o(nb_req), .bus_poll_o(nb_poll), .bus_mask_o(nb_mask),
    .bus_cmd_o(nb_cmd), .bus_len_o(nb_len), .bus_data_o(nb_data),
    .bus_ack_i(1'b0), .bus_rsp_len_i(8'd0), .bus_rsp_data_i('0),
    .reply_size_o(nb_size), .reply_data_o(nb_rdata),
    .irq_data_set_o(nb_irq_d), .irq_auto_set_o(nb_irq_a));

  always @(posedge clk) cyc <= cyc + 1;

  // bus responder
  initial begin
    int wctr;
    wctr = 0;
    forever begin
      @(negedge clk);
      if (bus_ack) bus_ack = 1'b0;
      else if (bus_req) begin
        if (wctr >= bus_delay) begin
          bus_ack   = 1'b1;
          rsp_len_w = 8'(rsp_n);
          for (int k = 0; k < MAX_RSP; k++) rsp_data_w[k*8 +: 8] = rsp_seed + 8'(k);
          cap_mask = bus_mask;
          if (!bus_poll) begin
            cap_cmd = bus_cmd;
            cap_len = int'(bus_len);
            cap_pl0 = bus_data[7:0];
            bus_cnt++;
          end
          wctr = 0;
        end else wctr++;
      end
    end
  end

  // output monitor
  initial begin
    logic prev_poll;
    prev_poll = 1'b0;
    forever begin
      @(negedge clk);
      if (irq_d) set_cnt++;
      if (irq_a) auto_cnt++;
      if (bus_req && bus_poll && !prev_poll) begin
        poll_cnt++;
        last_poll_t = cyc;
      end
      prev_poll = bus_req && bus_poll;
      if (nb_irq_d) nb_set++;
      if (nb_irq_a) nb_auto++;
      if (nb_req) nb_bus_seen++;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input bit kind, input int len, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1;
    req_kind  = kind;
    req_len   = LW'(len);
    req_data  = d;
    if (!kind && len >= 2 && !(d[7:0] == 8'h00 && d[15:8] == 8'h86)) norm_sent++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [63:0] mask_req(input logic [15:0] m);
    return {32'h0, m[7:0], m[15:8], 8'h86, 8'h00};
  endfunction

  task automatic idle_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_drain();
    int t;
    t = 0;
    while (bus_req && t < 100) begin @(negedge clk); t++; end
    @(negedge clk);
  endtask

  task automatic wait_poll(input string tag);
    int p, t;
    p = poll_cnt;
    t = 0;
    while (poll_cnt == p && t < 200) begin @(negedge clk); t++; end
    if (poll_cnt == p) chk(1'b0, tag, 0, 1);
    bus_drain();
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [47:0] exp_r;
    int s, b, p, t0, tl;
    bit ok_len;

    idle_wait(3);
    rst_n = 1'b1;
    idle_wait(2);
    chk(rep_size == 0 && !bus_req && !irq_d && !irq_a, "reset state", rep_size, 0);

    // R5 R6 R7 R11 sweep over length, declared payload and reply size
    for (int len = 2; len <= MAX_REQ; len++) begin
      for (int pl = 0; pl <= 5; pl++) begin
        d = '0;
        d[7:0]   = 8'h20 + 8'(len);
        d[15:8]  = 8'h11;
        d[23:16] = 8'(pl);
        for (int k = 3; k < MAX_REQ; k++) d[k*8 +: 8] = 8'h40 + 8'(k);
        rsp_n    = (len + pl) % 5;
        rsp_seed = 8'h90 + 8'(len);
        s = set_cnt; b = bus_cnt;
        send(1'b0, len, d);
        idle_wait(12);
        ok_len = (len >= 3) && (pl <= len - 3) && (pl <= CAP);
        chk(set_cnt == s + 1 && auto_cnt == 0, "R7 one data irq per request", set_cnt - s, 1);
        exp_r = '0;
        if (ok_len) begin
          chk(bus_cnt == b + 1, "R5 accepted request reaches bus", bus_cnt - b, 1);
          chk(cap_cmd == d[7:0] && cap_len == len - 3, "R11 bus command and length",
              {cap_cmd, 8'(cap_len)}, {d[7:0], 8'(len - 3)});
          if (len > 3) chk(cap_pl0 == 8'h43, "R11 first payload byte", cap_pl0, 8'h43);
          if (rsp_n > 0) begin
            exp_r[7:0]  = 8'h01;
            exp_r[15:8] = 8'(rsp_n);
            for (int k = 0; k < rsp_n; k++) exp_r[(k+2)*8 +: 8] = rsp_seed + 8'(k);
            chk(rep_size == 8'(rsp_n + 2) && rep_data == exp_r, "R6 success reply",
                rep_data, exp_r);
          end else
            chk(rep_size == 8'd1 && rep_data == exp_r, "R6 empty reply", rep_data, exp_r);
        end else begin
          chk(bus_cnt == b, "R5 bad length kept off bus", bus_cnt - b, 0);
          chk(rep_size == 8'd1 && rep_data == exp_r, "R6 failure reply", rep_size, 1);
        end
        ack_cnt = set_cnt;
      end
    end

    // R1 R2 R4 arm and periodic empty polls
    rsp_n = 0;
    s = set_cnt;
    send(1'b0, 4, mask_req(16'h1234));
    t0 = cyc;
    wait_poll("R2 first poll");
    chk(last_poll_t == t0 + PER, "R2 first poll one period after arm", last_poll_t, t0 + PER);
    chk(cap_mask == 16'h1234, "R1 mask byte order", cap_mask, 16'h1234);
    tl = last_poll_t;
    wait_poll("R4 second poll");
    chk(last_poll_t == tl + PER, "R4 re-arm after empty poll", last_poll_t, tl + PER);
    chk(set_cnt == s, "R3 empty poll raises nothing", set_cnt, s);

    // R3 data poll, then suppression while pending
    rsp_n = 3; rsp_seed = 8'h50;
    s = set_cnt;
    wait_poll("R3 data poll");
    rsp_n = 0;
    exp_r = 48'h0000_0052_5150;
    chk(set_cnt == s + 1 && auto_cnt == 1, "R3 both bits set", auto_cnt, 1);
    chk(rep_size == 8'd3 && rep_data == exp_r, "R3 raw poll data", rep_data, exp_r);
    tl = last_poll_t;
    p = poll_cnt;
    idle_wait(70);
    chk(poll_cnt == p, "R3 no query while data pending", poll_cnt, p);
    ack_cnt = set_cnt;
    wait_poll("R3 resume after ack");
    chk((last_poll_t - tl) % PER == 0, "R4 schedule kept while suppressed",
        (last_poll_t - tl) % PER, 0);

    // R2 same mask is a no-op
    tl = last_poll_t;
    idle_wait(10);
    send(1'b0, 4, mask_req(16'h1234));
    wait_poll("R2 same mask poll");
    chk(last_poll_t == tl + PER, "R2 same mask keeps schedule", last_poll_t, tl + PER);

    // R2 new mask restarts
    idle_wait(8);
    send(1'b0, 4, mask_req(16'h00ff));
    t0 = cyc;
    wait_poll("R2 new mask poll");
    chk(last_poll_t == t0 + PER, "R2 new mask restarts timer", last_poll_t, t0 + PER);
    chk(cap_mask == 16'h00ff, "R2 new mask on bus", cap_mask, 16'h00ff);

    // R1 wrong length mask setting ignored
    tl = last_poll_t;
    s = set_cnt;
    idle_wait(5);
    send(1'b0, 5, {24'h0, 8'hcd, 8'hab, 8'h86, 8'h00} | 64'h00_0000_0000);
    wait_poll("R1 poll after bad mask request");
    chk(last_poll_t == tl + PER && cap_mask == 16'h00ff, "R1 wrong length ignored",
        cap_mask, 16'h00ff);
    chk(set_cnt == s, "R1 no irq for mask request", set_cnt, s);

    // R2 zero mask stops
    send(1'b0, 4, mask_req(16'h0000));
    p = poll_cnt;
    idle_wait(100);
    chk(poll_cnt == p, "R2 zero mask stops polling", poll_cnt, p);

    // R8 poll-off
    send(1'b0, 4, mask_req(16'h0101));
    wait_poll("R8 re-armed poll");
    idle_wait(5);
    send(1'b1, 1, 64'h0);
    wait_poll("R8 poll-off with argument ignored");
    idle_wait(5);
    send(1'b1, 0, 64'h0);
    p = poll_cnt;
    idle_wait(100);
    chk(poll_cnt == p, "R8 poll-off stops timer", poll_cnt, p);
    send(1'b0, 4, mask_req(16'h0101));
    t0 = cyc;
    wait_poll("R8 mask cleared");
    chk(last_poll_t == t0 + PER, "R8 mask cleared so same value re-arms", last_poll_t, t0 + PER);
    send(1'b1, 0, 64'h0);

    // R9 request while busy
    idle_wait(5);
    bus_delay = 10; rsp_n = 1; rsp_seed = 8'h77;
    s = set_cnt;
    send(1'b0, 4, {32'h0, 8'h55, 8'h01, 8'h22, 8'h33});
    idle_wait(3);
    send(1'b0, 3, {40'h0, 8'h05, 8'h22, 8'h33});
    bus_drain();
    idle_wait(5);
    exp_r = 48'h0000_0077_0101;
    chk(set_cnt == s + 1, "R9 busy request dropped", set_cnt - s, 1);
    chk(rep_size == 8'd3 && rep_data == exp_r, "R9 reply from first request", rep_data, exp_r);
    ack_cnt = set_cnt;
    bus_delay = 2; rsp_n = 0;

    // R5 short requests
    s = set_cnt; b = bus_cnt;
    send(1'b0, 1, 64'h11);
    send(1'b0, 0, 64'h0);
    idle_wait(10);
    chk(set_cnt == s && bus_cnt == b, "R5 short request ignored", set_cnt - s, 0);

    // R10 no-bus instance
    chk(nb_set == norm_sent, "R10 every request answered", nb_set, norm_sent);
    chk(nb_bus_seen == 0 && nb_auto == 0, "R10 bus never used", nb_bus_seen, 0);
    chk(nb_size == 8'd1 && nb_rdata == '0, "R10 failure reply", nb_size, 1);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule